// File: doc/BRIEF.md
# Buffered Configuration Port Controller

This peripheral sits between a simple register bus and an on-chip configuration port. Software pushes 32-bit words into a deep transmit queue and then issues a command that drains the queue into the port as a valid/ready word stream. For readback, software programs a word count and issues a second command. The block then accepts exactly that many words from the port's return stream into a smaller receive queue, which software pops through a data window.

Software tracks progress by polling. A status word carries an idle ("done") flag, a readback-in-progress flag and three level inputs from the port. Two counters report free transmit slots and filled receive slots. Four queue events can raise an interrupt line. Each has a sticky status bit that is set on the event's rising edge and inverted by writing 1, a per-source enable, and a global gate. The control word also carries two self-clearing actions. One empties both queues. The other returns the whole block to its reset state.

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset, the status word at 0x110 reads {cfgerr, dalign, 1'b0, abort_n, 4'b1111, 1'b1} in bits 8..0. Vacancy at 0x114 reads 1024, occupancy at 0x118 reads 0, the registers at 0x1C, 0x20 and 0x28 read 0, and `irq` is low.
- R2: A bus write to 0x100 appends the data to the 1024-word transmit queue and lowers the vacancy at 0x114 by one. A write made while the vacancy is 0 is dropped.
- R3: Writing bit 0 of the control word at 0x10C while done is 1 starts a drain. The queued words leave on `cp_odata` in push order, one per cycle where `cp_ovalid` and `cp_oready` are both high. Done (status bit 0) reads 0 during the drain and returns to 1 once the queue is empty.
- R4: The readback size at 0x108 keeps only its low 12 bits. Writing control bit 1 while done is 1 starts a readback that accepts exactly that many words from the return stream. Status bit 6 reads 1 and bit 0 reads 0 until the count is reached.
- R5: When the 256-word receive queue is full, `cp_iready` is held low and no returned word is lost. Occupancy never exceeds 256.
- R6: A read of 0x104 while occupancy is 0 leaves the occupancy and the order of later words unchanged.
- R7: A start command issued while done is 0 is ignored. Control bit 0 takes precedence over bit 1 when both are written.
- R8: Control bit 2 empties both queues and leaves the enable, global enable and size registers unchanged.
- R9: Control bit 3 empties both queues, returns the sequencer to idle and clears the registers at 0x1C, 0x20, 0x28 and 0x108.
- R10: Interrupt status bits at 0x20 are bit 3 receive full, bit 2 transmit empty, bit 1 receive at least half full and bit 0 transmit at least half full. Each bit is set when its condition rises. Writing 1 to a bit inverts it.
- R11: `irq` is high exactly when bit 31 of 0x1C is 1 and some status bit at 0x20 is 1 together with the same bit of the enable register at 0x28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Interrupt request |
| cp_odata | output | 32 | Word sent toward the configuration port |
| cp_ovalid | output | 1 | Outgoing word is valid |
| cp_oready | input | 1 | Port accepts the outgoing word |
| cp_idata | input | 32 | Readback word from the port |
| cp_ivalid | input | 1 | Readback word is valid |
| cp_iready | output | 1 | Block accepts the readback word |
| cp_cfgerr | input | 1 | Configuration error level from the port |
| cp_dalign | input | 1 | Data-aligned level from the port |
| cp_abort_n | input | 1 | Active-low abort level from the port |

## Verification
The assertions assume that read and write strobes never occur in the same cycle. They also assume that the port completes a transfer only in a cycle where both valid and ready are high. The stimulus issues one bus access at a time, and the bus and port drivers change their inputs only between clock edges. The stimulus sends control commands during a drain only while the outgoing stream is stalled, so no word is taken by the port in the cycle its queue is cleared. Receive-queue pops are bounded by a prior occupancy read, except in the one deliberate empty-read case.

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl #(
  parameter int AW       = 9,
  parameter int DW       = 32,
  parameter int WF_DEPTH = 1024,
  parameter int RF_DEPTH = 256,
  parameter int SIZE_W   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic [DW-1:0] cp_odata,
  output logic          cp_ovalid,
  input  logic          cp_oready,
  input  logic [DW-1:0] cp_idata,
  input  logic          cp_ivalid,
  output logic          cp_iready,
  input  logic          cp_cfgerr,
  input  logic          cp_dalign,
  input  logic          cp_abort_n
);

  localparam int WA = $clog2(WF_DEPTH);
  localparam int RA = $clog2(RF_DEPTH);
  localparam int WC = $clog2(WF_DEPTH + 1);
  localparam int RC = $clog2(RF_DEPTH + 1);
  localparam logic [WC-1:0] WF_FULL = WC'(WF_DEPTH);
  localparam logic [WC-1:0] WF_HALF = WC'(WF_DEPTH / 2);
  localparam logic [RC-1:0] RF_FULL = RC'(RF_DEPTH);
  localparam logic [RC-1:0] RF_HALF = RC'(RF_DEPTH / 2);

  localparam logic [AW-1:0] A_GIE = AW'('h01C);
  localparam logic [AW-1:0] A_ISR = AW'('h020);
  localparam logic [AW-1:0] A_IER = AW'('h028);
  localparam logic [AW-1:0] A_WF  = AW'('h100);
  localparam logic [AW-1:0] A_RF  = AW'('h104);
  localparam logic [AW-1:0] A_SZ  = AW'('h108);
  localparam logic [AW-1:0] A_CTL = AW'('h10C);
  localparam logic [AW-1:0] A_ST  = AW'('h110);
  localparam logic [AW-1:0] A_WV  = AW'('h114);
  localparam logic [AW-1:0] A_RO  = AW'('h118);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} seq_t;
  seq_t state;

  logic [DW-1:0]     wf_mem [WF_DEPTH];
  logic [DW-1:0]     rf_mem [RF_DEPTH];
  logic [WA-1:0]     wf_wptr, wf_rptr;
  logic [RA-1:0]     rf_wptr, rf_rptr;
  logic [WC-1:0]     wf_count;
  logic [RC-1:0]     rf_count;
  logic [SIZE_W-1:0] size_q, rd_left;
  logic              gie;
  logic [3:0]        ier, isr, cond_q;

  wire ctl_wr = bus_wr && bus_addr == A_CTL;
  wire sw_rst = ctl_wr && bus_wdata[3];
  wire flush  = sw_rst || (ctl_wr && bus_wdata[2]);
  wire done   = state == S_IDLE;
  wire rip    = state == S_RD;
  wire go_wr  = ctl_wr && bus_wdata[0] && done && !sw_rst;
  wire go_rd  = ctl_wr && bus_wdata[1] && !bus_wdata[0] && done && !sw_rst;

  wire wf_push = bus_wr && bus_addr == A_WF && wf_count != WF_FULL;
  wire wf_pop  = cp_ovalid && cp_oready;
  wire rf_pop  = bus_rd && bus_addr == A_RF && rf_count != '0;
  wire rf_push = cp_ivalid && cp_iready;

  assign cp_ovalid = state == S_WR && wf_count != '0;
  assign cp_odata  = wf_mem[wf_rptr];
  assign cp_iready = rip && rd_left != '0 && rf_count != RF_FULL;

  wire [3:0] cond = {rf_count == RF_FULL, wf_count == '0,
                     rf_count >= RF_HALF, wf_count >= WF_HALF};
  wire [3:0] rise = cond & ~cond_q;
  wire [3:0] tgl  = (bus_wr && bus_addr == A_ISR) ? bus_wdata[3:0] : 4'h0;
  assign irq = gie && |(isr & ier);

  wire [8:0]    status  = {cp_cfgerr, cp_dalign, rip, cp_abort_n, 4'hF, done};
  wire [WC-1:0] vacancy = WF_FULL - wf_count;

  always_ff @(posedge clk) if (wf_push) wf_mem[wf_wptr] <= bus_wdata;
  always_ff @(posedge clk) if (rf_push) rf_mem[rf_wptr] <= cp_idata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wf_wptr <= '0; wf_rptr <= '0; wf_count <= '0;
      rf_wptr <= '0; rf_rptr <= '0; rf_count <= '0;
    end else if (flush) begin
      wf_wptr <= '0; wf_rptr <= '0; wf_count <= '0;
      rf_wptr <= '0; rf_rptr <= '0; rf_count <= '0;
    end else begin
      if (wf_push) wf_wptr <= wf_wptr + 1'b1;
      if (wf_pop)  wf_rptr <= wf_rptr + 1'b1;
      if (rf_push) rf_wptr <= rf_wptr + 1'b1;
      if (rf_pop)  rf_rptr <= rf_rptr + 1'b1;
      wf_count <= wf_count + WC'(wf_push) - WC'(wf_pop);
      rf_count <= rf_count + RC'(rf_push) - RC'(rf_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; rd_left <= '0;
    end else if (sw_rst) begin
      state <= S_IDLE; rd_left <= '0;
    end else begin
      case (state)
        S_IDLE: if (go_wr) state <= S_WR;
                else if (go_rd) begin state <= S_RD; rd_left <= size_q; end
        S_WR:   if (wf_count == '0) state <= S_IDLE;
        S_RD:   if (rd_left == '0) state <= S_IDLE;
                else if (rf_push) rd_left <= rd_left - SIZE_W'(1);
        default: state <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gie <= 1'b0; ier <= '0; isr <= '0; size_q <= '0; cond_q <= 4'b0100;
    end else if (sw_rst) begin
      gie <= 1'b0; ier <= '0; isr <= '0; size_q <= '0; cond_q <= 4'b0100;
    end else begin
      cond_q <= cond;
      isr    <= (isr ^ tgl) | rise;
      if (bus_wr && bus_addr == A_GIE) gie    <= bus_wdata[DW-1];
      if (bus_wr && bus_addr == A_IER) ier    <= bus_wdata[3:0];
      if (bus_wr && bus_addr == A_SZ)  size_q <= bus_wdata[SIZE_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd)
      case (bus_addr)
        A_GIE:   bus_rdata <= {gie, {(DW-1){1'b0}}};
        A_ISR:   bus_rdata <= DW'(isr);
        A_IER:   bus_rdata <= DW'(ier);
        A_RF:    bus_rdata <= rf_mem[rf_rptr];
        A_SZ:    bus_rdata <= DW'(size_q);
        A_ST:    bus_rdata <= DW'(status);
        A_WV:    bus_rdata <= DW'(vacancy);
        A_RO:    bus_rdata <= DW'(rf_count);
        default: bus_rdata <= '0;
      endcase

  assert_wf_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wf_count <= WF_FULL);

  assert_rf_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_count <= RF_FULL);

  assert_rf_hold_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_count == RF_FULL && !rf_pop && !flush) |=> rf_count == RF_FULL);

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_count == '0 && state != S_RD) |=> rf_count == '0);

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR && ctl_wr && bus_wdata[1]) |=> state != S_RD);

  assert_sw_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (wf_count == '0 && rf_count == '0 && ier == '0 && !gie && state == S_IDLE));

endmodule

// File: tb/test_cfgport_ctrl.sv
module test_cfgport_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [8:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0, bus_rdata, cp_odata, cp_idata = '0;
  logic        irq, cp_ovalid, cp_oready = 0, cp_ivalid = 0, cp_iready;
  logic        cp_cfgerr = 0, cp_dalign = 1, cp_abort_n = 1;

  always #4 clk = ~clk;

  cfgport_ctrl i_cfgport_ctrl (.*);

  int n_tests = 0, n_fail = 0;
  logic [31:0] wq[$], rq[$];
  int wf_model = 0;
  int o_mode = 0;
  bit i_en = 0;
  logic [31:0] gen = 32'hA000_0000;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (o_mode == 0) cp_oready = 0;
    else if (o_mode == 1) cp_oready = 1;
    else cp_oready = ($urandom % 3) != 0;
    if (rst_n && cp_ovalid && cp_oready) begin
      if (wq.size() == 0) chk("R3 unexpected outgoing word", cp_odata, 32'hx);
      else chk("R3 outgoing word order", cp_odata, wq.pop_front());
    end
    cp_ivalid = i_en && (($urandom % 4) != 0);
    cp_idata  = gen;
    if (rst_n && cp_ivalid && cp_iready) begin
      rq.push_back(gen);
      gen = gen + 1;
    end
  end

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic push(logic [31:0] d);
    if (wf_model < 1024) begin wq.push_back(d); wf_model++; end
    wr(9'h100, d);
  endtask

  task automatic wait_done(string tag);
    logic [31:0] s;
    for (int k = 0; k < 5000; k++) begin
      rd(9'h110, s);
      if (s[0]) return;
    end
    chk(tag, 32'h0, 32'h1);
  endtask

  task automatic pop_rf(string tag);
    logic [31:0] d;
    rd(9'h104, d);
    if (rq.size() == 0) chk(tag, d, 32'hx);
    else chk(tag, d, rq.pop_front());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(9'h110, d); chk("R1 status", d, 32'h0BF);
    rd(9'h114, d); chk("R1 vacancy", d, 1024);
    rd(9'h118, d); chk("R1 occupancy", d, 0);
    rd(9'h020, d); chk("R1 isr", d, 0);
    rd(9'h01C, d); chk("R1 gie", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    wr(9'h01C, 32'h8000_0000);
    wr(9'h028, 32'h4);
    for (int k = 0; k < 5; k++) push(32'h1000 + k);
    rd(9'h114, d); chk("R2 vacancy after 5", d, 1019);
    chk("R11 irq low before event", {31'b0, irq}, 0);
    o_mode = 2;
    wr(9'h10C, 32'h1);
    rd(9'h110, d); chk("R3 done low while draining", {31'b0, d[0]}, 0);
    wait_done("R3 drain completes");
    wf_model = 0;
    chk("R3 all words sent", wq.size(), 0);
    rd(9'h020, d); chk("R10 transmit-empty event", d, 32'h4);
    chk("R11 irq raised", {31'b0, irq}, 1);
    wr(9'h020, 32'h4);
    rd(9'h020, d); chk("R10 toggle clears", d, 0);
    chk("R11 irq dropped", {31'b0, irq}, 0);

    o_mode = 0;
    for (int k = 0; k < 1026; k++) push(32'h2000 + k);
    rd(9'h114, d); chk("R2 full vacancy", d, 0);
    rd(9'h020, d); chk("R10 half-full event", d, 32'h1);
    wr(9'h10C, 32'h4);
    wq.delete(); wf_model = 0;
    rd(9'h114, d); chk("R8 flush empties", d, 1024);
    rd(9'h028, d); chk("R8 enable kept", d, 32'h4);
    rd(9'h020, d); chk("R10 empty rises again", d, 32'h5);
    wr(9'h020, 32'h5);

    i_en = 1;
    wr(9'h108, 32'h0000_1005);
    rd(9'h108, d); chk("R4 size 12 bits", d, 32'h005);
    wr(9'h10C, 32'h2);
    rd(9'h110, d); chk("R4 readback active", d & 32'h41, 32'h40);
    wait_done("R4 readback completes");
    repeat (10) @(negedge clk);
    rd(9'h118, d); chk("R4 exact count", d, 5);
    for (int k = 0; k < 5; k++) pop_rf("R4 readback data");
    rd(9'h104, d);
    rd(9'h118, d); chk("R6 empty read harmless", d, 0);

    wr(9'h108, 300);
    wr(9'h10C, 32'h2);
    for (int k = 0; k < 3000; k++) begin
      rd(9'h118, d);
      if (d == 256) break;
    end
    repeat (20) @(negedge clk);
    rd(9'h118, d); chk("R5 occupancy capped", d, 256);
    rd(9'h110, d); chk("R5 still active", {31'b0, d[0]}, 0);
    rd(9'h020, d); chk("R10 receive full and half", d & 32'hA, 32'hA);
    for (int k = 0; k < 100 && rq.size() > 0; k++) begin
      int n;
      rd(9'h118, d); n = int'(d);
      for (int j = 0; j < n; j++) pop_rf("R5 no word lost");
    end
    wait_done("R5 readback completes");
    chk("R5 all 300 returned", gen - 32'hA000_0000, 305);
    chk("R5 queue drained", rq.size(), 0);

    i_en = 1;
    for (int k = 0; k < 20; k++) push(32'h3000 + k);
    wr(9'h10C, 32'h1);
    wr(9'h10C, 32'h2);
    rd(9'h110, d); chk("R7 start ignored while busy", d & 32'h41, 0);
    o_mode = 2;
    wait_done("R7 drain completes");
    wf_model = 0;
    repeat (5) @(negedge clk);
    rd(9'h118, d); chk("R7 no readback ran", d, 0);
    i_en = 0;

    o_mode = 0;
    wr(9'h01C, 32'h8000_0000);
    wr(9'h028, 32'hF);
    wr(9'h108, 7);
    for (int k = 0; k < 3; k++) push(32'h4000 + k);
    wr(9'h10C, 32'h8);
    wq.delete(); wf_model = 0;
    rd(9'h028, d); chk("R9 enable cleared", d, 0);
    rd(9'h01C, d); chk("R9 gie cleared", d, 0);
    rd(9'h108, d); chk("R9 size cleared", d, 0);
    rd(9'h114, d); chk("R9 queue emptied", d, 1024);
    rd(9'h020, d); chk("R9 isr cleared", d, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule